// File: doc/BRIEF.md
# Zero-Address Stack Evaluation Unit

This block evaluates expressions on a last-in first-out stack of data words held in an internal register file. Commands carry no operand addresses. Push takes a value from the command's data input. Pop hands the top value out on a data port. Add and subtract consume the two top entries and leave one result. A depth register tracks the stack pointer implicitly, and each command changes it by its own fixed amount: +1 for push, -1 for pop, add and subtract.

A command is offered with a valid/ready handshake and completes in the clock cycle in which it is accepted. A command that would overflow or underflow the stack is dropped and leaves the stack untouched. It sets an error flag that stays set until reset. The top entry can always be read on a dedicated output, and the occupancy on the depth output.

Top module: `stack_eval_unit`

## Requirements
- R1: After reset, depth_o is 0, top_o is 0, err_o is 0 and pop_valid_o is 0.
- R2: An accepted push (cmd_op_i = 0) with fewer than DEPTH entries raises depth_o by one after the clock edge, and top_o then shows cmd_data_i.
- R3: An accepted pop (cmd_op_i = 1) on a non-empty stack lowers depth_o by one. In the next cycle pop_data_o holds the former top, and pop_valid_o is high for exactly that one cycle.
- R4: An accepted add (cmd_op_i = 2) with at least two entries lowers depth_o by one. top_o then shows the former top plus the entry below it, modulo 2^WIDTH.
- R5: An accepted subtract (cmd_op_i = 3) with at least two entries lowers depth_o by one. top_o then shows the former top minus the entry below it, modulo 2^WIDTH.
- R6: A push with DEPTH entries leaves depth_o and top_o unchanged and sets err_o.
- R7: A pop on an empty stack leaves depth_o at 0, gives no pop_valid_o pulse and sets err_o.
- R8: An add or subtract with fewer than two entries leaves depth_o and top_o unchanged and sets err_o.
- R9: Once set, err_o stays high until rst_ni is asserted, including across later legal commands.
- R10: cmd_ready_o is high out of reset. A cycle with cmd_valid_i low changes neither depth_o nor top_o, whatever cmd_op_i and cmd_data_i hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command offered |
| cmd_ready_o | output | 1 | Command can be taken |
| cmd_op_i | input | 2 | 0 push, 1 pop, 2 add, 3 subtract |
| cmd_data_i | input | WIDTH | Value to push |
| pop_data_o | output | WIDTH | Popped value |
| pop_valid_o | output | 1 | One-cycle strobe for pop_data_o |
| top_o | output | WIDTH | Current top entry, 0 when empty |
| depth_o | output | $clog2(DEPTH+1) | Entry count |
| err_o | output | 1 | Sticky overflow/underflow flag |

## Verification
The bench pushes distinct values and pops them back, so that a swapped read index or a write to the wrong slot shows up as a wrong order on pop_data_o. Operand pairs chosen so that a+b and a-b differ from b-a and from each other distinguish the operand order in subtraction. Values near 0xFFFF exercise wraparound in both directions. The stack is filled to exactly DEPTH and then overfilled, and it is drained to empty and then popped and added again, which separates each boundary test from its neighbour. Idle cycles that carry a push opcode with garbage data confirm that the handshake gates every state change.

// File: rtl/stack_eval_pkg.sv
package stack_eval_pkg;
  typedef enum logic [1:0] {
    OP_PUSH = 2'd0,
    OP_POP  = 2'd1,
    OP_ADD  = 2'd2,
    OP_SUB  = 2'd3
  } stack_op_e;
endpackage

// File: rtl/stack_regfile.sv
module stack_regfile #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned WIDTH = 16,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [AW-1:0]    raddr_a_i,
  input  logic [AW-1:0]    raddr_b_i,
  output logic [WIDTH-1:0] rdata_a_o,
  output logic [WIDTH-1:0] rdata_b_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             mem_q[g] <= '0;
      else if (we_i && waddr_i == AW'(g))      mem_q[g] <= wdata_i;
    end
  end

  assign rdata_a_o = mem_q[raddr_a_i];
  assign rdata_b_o = mem_q[raddr_b_i];
endmodule

// File: rtl/stack_alu.sv
module stack_alu #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             sub_i,
  input  logic [WIDTH-1:0] top_i,
  input  logic [WIDTH-1:0] below_i,
  output logic [WIDTH-1:0] res_o
);
  // former top is the minuend
  assign res_o = sub_i ? (top_i - below_i) : (top_i + below_i);
endmodule

// File: rtl/stack_seq_ctrl.sv
module stack_seq_ctrl
  import stack_eval_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned WIDTH = 16,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fire_i,
  input  stack_op_e        op_i,
  input  logic [WIDTH-1:0] top_data_i,
  output logic             we_o,
  output logic             wsel_push_o,
  output logic [AW-1:0]    waddr_o,
  output logic [AW-1:0]    top_idx_o,
  output logic [AW-1:0]    below_idx_o,
  output logic [CW-1:0]    depth_o,
  output logic             err_o,
  output logic [WIDTH-1:0] pop_data_o,
  output logic             pop_valid_o
);
  logic [CW-1:0] depth_q, depth_d, dm1, dm2;
  logic          legal, err_q, pop_valid_q;
  logic [WIDTH-1:0] pop_data_q;

  assign dm1 = depth_q - CW'(1);
  assign dm2 = depth_q - CW'(2);
  assign top_idx_o   = dm1[AW-1:0];
  assign below_idx_o = dm2[AW-1:0];

  always_comb begin
    unique case (op_i)
      OP_PUSH: legal = (depth_q != CW'(DEPTH));
      OP_POP:  legal = (depth_q != '0);
      default: legal = (depth_q >= CW'(2));
    endcase
  end

  assign we_o        = fire_i && legal && (op_i != OP_POP);
  assign wsel_push_o = (op_i == OP_PUSH);
  assign waddr_o     = (op_i == OP_PUSH) ? depth_q[AW-1:0] : below_idx_o;

  always_comb begin
    depth_d = depth_q;
    if (fire_i && legal) depth_d = (op_i == OP_PUSH) ? depth_q + CW'(1) : dm1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      depth_q     <= '0;
      err_q       <= 1'b0;
      pop_valid_q <= 1'b0;
      pop_data_q  <= '0;
    end else begin
      depth_q     <= depth_d;
      pop_valid_q <= fire_i && legal && (op_i == OP_POP);
      if (fire_i && !legal) err_q <= 1'b1;
      if (fire_i && legal && op_i == OP_POP) pop_data_q <= top_data_i;
    end
  end

  assign depth_o     = depth_q;
  assign err_o       = err_q;
  assign pop_valid_o = pop_valid_q;
  assign pop_data_o  = pop_data_q;
endmodule

// File: rtl/stack_eval_unit.sv
module stack_eval_unit
  import stack_eval_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned WIDTH = 16,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  output logic             cmd_ready_o,
  input  logic [1:0]       cmd_op_i,
  input  logic [WIDTH-1:0] cmd_data_i,
  output logic [WIDTH-1:0] pop_data_o,
  output logic             pop_valid_o,
  output logic [WIDTH-1:0] top_o,
  output logic [CW-1:0]    depth_o,
  output logic             err_o
);
  stack_op_e        op;
  logic             fire, we, wsel_push;
  logic [AW-1:0]    waddr, top_idx, below_idx;
  logic [WIDTH-1:0] rd_top, rd_below, alu_res, wdata;
  logic [CW-1:0]    depth;

  assign op          = stack_op_e'(cmd_op_i);
  assign cmd_ready_o = 1'b1;
  assign fire        = cmd_valid_i && cmd_ready_o;

  stack_seq_ctrl #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fire_i      (fire),
    .op_i        (op),
    .top_data_i  (rd_top),
    .we_o        (we),
    .wsel_push_o (wsel_push),
    .waddr_o     (waddr),
    .top_idx_o   (top_idx),
    .below_idx_o (below_idx),
    .depth_o     (depth),
    .err_o       (err_o),
    .pop_data_o  (pop_data_o),
    .pop_valid_o (pop_valid_o)
  );

  stack_alu #(.WIDTH(WIDTH)) u_alu (
    .sub_i   (op == OP_SUB),
    .top_i   (rd_top),
    .below_i (rd_below),
    .res_o   (alu_res)
  );

  assign wdata = wsel_push ? cmd_data_i : alu_res;

  stack_regfile #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (we),
    .waddr_i   (waddr),
    .wdata_i   (wdata),
    .raddr_a_i (top_idx),
    .raddr_b_i (below_idx),
    .rdata_a_o (rd_top),
    .rdata_b_o (rd_below)
  );

  assign depth_o = depth;
  assign top_o   = (depth == '0) ? '0 : rd_top;
endmodule

// File: rtl/stack_eval_chk.sv
module stack_eval_chk #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned WIDTH = 16,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cmd_valid_i,
  input logic             cmd_ready_o,
  input logic [1:0]       cmd_op_i,
  input logic [WIDTH-1:0] cmd_data_i,
  input logic [WIDTH-1:0] pop_data_o,
  input logic             pop_valid_o,
  input logic [WIDTH-1:0] top_o,
  input logic [CW-1:0]    depth_o,
  input logic             err_o
);
  logic acc;
  assign acc = cmd_valid_i && cmd_ready_o;

  // R2
  a_r2_push_grows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && cmd_op_i == 2'd0 && depth_o != CW'(DEPTH) |=> depth_o == $past(depth_o) + CW'(1) && top_o == $past(cmd_data_i));
  // R3
  a_r3_pop_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && cmd_op_i == 2'd1 && depth_o != '0 |=> pop_valid_o && pop_data_o == $past(top_o));
  // R7
  a_r7_no_spurious_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_valid_o |-> $past(acc && cmd_op_i == 2'd1 && depth_o != '0));
  // R6
  a_r6_depth_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    depth_o <= CW'(DEPTH));
  // R8
  a_r8_short_arith: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && cmd_op_i[1] && depth_o < CW'(2) |=> $stable(depth_o) && $stable(top_o) && err_o);
  // R9
  a_r9_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
  // R10
  a_r10_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_i |=> $stable(depth_o) && $stable(top_o) && !pop_valid_o);
  a_r10_ready: assert property (@(posedge clk_i) disable iff (!rst_ni) cmd_ready_o);
endmodule

bind stack_eval_unit stack_eval_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_i (cmd_valid_i),
  .cmd_ready_o (cmd_ready_o),
  .cmd_op_i    (cmd_op_i),
  .cmd_data_i  (cmd_data_i),
  .pop_data_o  (pop_data_o),
  .pop_valid_o (pop_valid_o),
  .top_o       (top_o),
  .depth_o     (depth_o),
  .err_o       (err_o)
);

// File: tb/stack_eval_unit_tb.sv
module stack_eval_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int WIDTH = 16;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cmd_valid = 1'b0, cmd_ready;
  logic [1:0] cmd_op = '0;
  logic [WIDTH-1:0] cmd_data = '0, pop_data, top;
  logic pop_valid, err;
  logic [CW-1:0] depth;

  int checks = 0, errors = 0;
  logic [WIDTH-1:0] m_stk [DEPTH];
  int m_depth = 0;
  bit m_err = 0;
  logic [WIDTH-1:0] exp_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  stack_eval_unit #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .cmd_op_i(cmd_op), .cmd_data_i(cmd_data), .pop_data_o(pop_data), .pop_valid_o(pop_valid),
    .top_o(top), .depth_o(depth), .err_o(err));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int m_top();
    return (m_depth == 0) ? 0 : int'(m_stk[m_depth-1]);
  endfunction

  // monitor: compares every pop strobe against the scoreboard queue
  always @(negedge clk) begin
    if (rst_ni && pop_valid) begin
      if (exp_q.size() == 0) chk("R7 unexpected pop strobe", 1, 0);
      else chk("R3 pop data", int'(pop_data), int'(exp_q.pop_front()));
    end
  end

  // driver: issue one command at a negedge, update model, check after the edge
  task automatic do_cmd(input logic [1:0] op, input logic [WIDTH-1:0] d, input string req);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
    case (op)
      2'd0: if (m_depth < DEPTH) begin m_stk[m_depth] = d; m_depth++; end else m_err = 1;
      2'd1: if (m_depth > 0) begin exp_q.push_back(m_stk[m_depth-1]); m_depth--; end else m_err = 1;
      default: if (m_depth >= 2) begin
        m_stk[m_depth-2] = (op == 2'd3) ? m_stk[m_depth-1] - m_stk[m_depth-2]
                                        : m_stk[m_depth-1] + m_stk[m_depth-2];
        m_depth--;
      end else m_err = 1;
    endcase
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'd0; cmd_data = 16'hDEAD;
    chk({req, " depth"}, int'(depth), m_depth);
    chk({req, " top"}, int'(top), m_top());
    chk({req, " err"}, int'(err), int'(m_err));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    chk("watchdog", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    // R1 reset state
    chk("R1 depth", int'(depth), 0);
    chk("R1 top", int'(top), 0);
    chk("R1 err", int'(err), 0);
    chk("R1 pop_valid", int'(pop_valid), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R10 ready", int'(cmd_ready), 1);
    // R2 pushes, R3 pops in LIFO order
    do_cmd(2'd0, 16'h0011, "R2 push");
    do_cmd(2'd0, 16'h0022, "R2 push");
    do_cmd(2'd0, 16'h0033, "R2 push");
    do_cmd(2'd1, 16'h0, "R3 pop");
    @(negedge clk);
    chk("R3 one-cycle strobe", int'(pop_valid), 0);
    do_cmd(2'd1, 16'h0, "R3 pop");
    // R4 add, R5 sub with order-sensitive operands
    do_cmd(2'd0, 16'h0005, "R2 push");
    do_cmd(2'd4 - 2'd2, 16'h0, "R4 add");          // 5 + 0x11 = 0x16
    do_cmd(2'd0, 16'h0040, "R2 push");
    do_cmd(2'd3, 16'h0, "R5 sub");                  // 0x40 - 0x16 = 0x2a
    do_cmd(2'd0, 16'hFFFF, "R2 push");
    do_cmd(2'd0, 16'h0003, "R2 push");
    do_cmd(2'd2, 16'h0, "R4 add wrap");             // 3 + FFFF = 2
    do_cmd(2'd0, 16'h0007, "R2 push");
    do_cmd(2'd0, 16'h0001, "R2 push");
    do_cmd(2'd3, 16'h0, "R5 sub wrap");             // 1 - 7 = FFFA
    // R10 idle cycles with garbage on the command lines
    cmd_op = 2'd0; cmd_data = 16'hBEEF;
    repeat (3) @(negedge clk);
    chk("R10 idle depth", int'(depth), m_depth);
    chk("R10 idle top", int'(top), m_top());
    // drain to empty
    while (m_depth > 0) do_cmd(2'd1, 16'h0, "R3 pop");
    chk("R1 no error yet", int'(err), 0);
    // R7 pop empty
    do_cmd(2'd1, 16'h0, "R7 pop empty");
    @(negedge clk);
    chk("R7 no strobe", int'(pop_valid), 0);
    // R8 arithmetic with 0 and 1 entries
    do_cmd(2'd2, 16'h0, "R8 add empty");
    do_cmd(2'd0, 16'h0099, "R2 push");
    do_cmd(2'd3, 16'h0, "R8 sub one");
    do_cmd(2'd2, 16'h0, "R8 add one");
    // fill to DEPTH, then overflow
    for (int i = 1; i < DEPTH; i++) do_cmd(2'd0, 16'(16'h0100 + i), "R2 fill");
    chk("R6 full depth", int'(depth), DEPTH);
    do_cmd(2'd0, 16'h7777, "R6 push full");
    // R9 error survives legal traffic
    do_cmd(2'd2, 16'h0, "R9 add after err");
    do_cmd(2'd1, 16'h0, "R9 pop after err");
    chk("R9 sticky", int'(err), 1);
    repeat (2) @(negedge clk);
    chk("R3 all pops seen", exp_q.size(), 0);
    // reset clears error
    rst_ni = 1'b0; m_depth = 0; m_err = 0;
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R9 err cleared by reset", int'(err), 0);
    chk("R1 depth after reset", int'(depth), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule